// File: doc/BRIEF.md
# Watchdog Timer with Sequence-Checked Restart

This block is a 16-bit down/up counter that serves either as a general interval timer or as a system watchdog. Software sets it up through a control word, a reload value and a restart register. Counting is paced by a prescaler that divides the block clock by 1, 16 or 256. In timer use, each expiry sets a sticky interrupt, which a restart-register write acknowledges. In periodic mode the counter reloads on expiry. In free-running mode it wraps through the whole 16-bit range.

Setting the watchdog bit turns expiry into a one-cycle reset request, unless the interrupt option is selected. The control word then locks until the next reset. Software keeps the watchdog alive by writing the restart register, which reloads the timeout. With secure restart enabled, each restart write must equal the next value of a hidden 8-bit LFSR sequence. Software seeds the sequence before entering watchdog mode. A wrong value requests a reset at once. Software has to track the sequence itself, because the state cannot be read back.

Top module: `wdt_lfsr_timer`

## Requirements
- R1: After `rst`, `irq` and `rst_req` are 0, the control word is all zeros (timer stopped, down-counting, free-running, watchdog off) and the counter and reload value are 0.
- R2: The counter moves only on prescaler ticks. The prescale field (control bits 3:2) divides the clock by 1 for 00, by 16 for 01, by 256 for 10, and by 1 for 11. With reload value L and counting down from the control write, expiry falls on clock edge D*(L+1) after that write, where D is the divisor.
- R3: A load write (`load_we`) sets both the reload value and the counter. With control bit 8 = 0 the counter counts down and expires when a tick finds it at 0. With control bit 6 = 1 (periodic) it then reloads from the reload value.
- R4: With control bit 8 = 1 the counter counts up and expires when a tick finds it at 0xFFFF. Periodic mode then reloads it.
- R5: With control bit 6 = 0 (free-running) the counter does not reload on expiry. It wraps to 0 when counting up, or to 0xFFFF when counting down.
- R6: In timer mode (control bit 5 = 0) every expiry sets `irq`. `irq` stays set until a restart write (`clr_we`) is made while the timer is enabled (control bit 7 = 1); the flag clears on that write's edge.
- R7: Restart writes made while the timer is disabled do not change `irq` or the count.
- R8: In watchdog mode (control bit 5 = 1) with control bit 1 = 0, expiry raises `rst_req` for exactly one cycle and leaves `irq` unchanged. `rst_req` is never raised outside watchdog mode.
- R9: In watchdog mode with control bit 1 = 1, expiry sets the sticky `irq` instead of raising `rst_req`.
- R10: In watchdog mode without secure restart (control bit 4 = 0), a restart write of any value reloads the counter from the reload value. This starts a new timeout.
- R11: In watchdog mode with secure restart (control bit 4 = 1), a restart write equal to the expected LFSR value reloads the counter and advances the LFSR. The next state is the old state shifted left by one, XORed with 0x63 when the old bit 7 was 1 (polynomial x^8+x^6+x^5+x+1). Any other value raises `rst_req` on the write's edge and leaves the LFSR unchanged. A restart write made outside watchdog mode loads the LFSR seed from bits 7:0. Seed 0xAA gives the accepted values 0xAA, 0x37, 0x6E, 0xDC.
- R12: When the seed is 0x00, every secure restart write raises `rst_req`, including a write of 0x00.
- R13: Once the control word has the watchdog bit set, control writes are ignored until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write `wdata[8:1]` into the control word |
| load_we | input | 1 | Write `wdata` as the reload value and the counter |
| clr_we | input | 1 | Restart-register write; `wdata[7:0]` is the value |
| wdata | input | 16 | Write data shared by the three registers |
| irq | output | 1 | Sticky interrupt flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The embedded assertions check four things on every cycle: the counter holds between ticks, the prescaler never ticks on two neighbouring cycles at /16 or /256, the control word stays frozen once watchdog mode is on, and `rst_req` only appears in watchdog mode. They also check that `irq` only falls after an enabled restart write or reset, and that a non-zero LFSR never collapses to zero. Other behaviour can only be shown by the bench's scenarios. This covers the exact expiry edges for each prescale and direction, periodic reload versus free-running wrap, the seeded sequence 0xAA, 0x37, 0x6E and 0xDC with a rejected 0x66, and the zero-seed trap.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PSC_DIV1   = 2'b00,
    PSC_DIV16  = 2'b01,
    PSC_DIV256 = 2'b10,
    PSC_ALT1   = 2'b11
  } psc_e;

  // Control word as seen from wdata[8:1]; field order follows bit position.
  typedef struct packed {
    logic up;        // bit 8
    logic en;        // bit 7
    logic periodic;  // bit 6
    logic wd;        // bit 5
    logic secure;    // bit 4
    psc_e psc;       // bits 3:2
    logic wd_irq;    // bit 1
  } ctl_t;

  localparam int CTL_LSB = 1;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int LOG_MID = 4,
  parameter int LOG_HI  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  psc_e sel,
  output logic tick
);

  logic [LOG_HI-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  always_comb begin
    case (sel)
      PSC_DIV16:  tick = run & (&div_q[LOG_MID-1:0]);
      PSC_DIV256: tick = run & (&div_q);
      default:    tick = run;
    endcase
  end

  AST_PSC_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && (sel == PSC_DIV16 || sel == PSC_DIV256)) |=> (!tick || sel == PSC_DIV1 || sel == PSC_ALT1)); // R2

endmodule

// File: rtl/wdt_lfsr.sv
module wdt_lfsr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   TAPS = 'h63
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] nxt;

  always_comb nxt = {state[W-2:0], 1'b0} ^ (state[W-1] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (rst)       state <= '0;
    else if (load) state <= seed;
    else if (step) state <= nxt;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (state != '0 && !load) |=> (state != '0)); // R11

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         count_up,
  input  logic         periodic,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  input  logic         restart,
  output logic         expire
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_q;
  logic         terminal;

  always_comb begin
    terminal = count_up ? (cnt_q == TOP) : (cnt_q == '0);
    expire   = tick & terminal & ~load_wr & ~restart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_wr) begin
      cnt_q    <= load_val;
      reload_q <= load_val;
    end else if (restart) begin
      cnt_q <= reload_q;
    end else if (tick) begin
      if (terminal && periodic) cnt_q <= reload_q;
      else if (count_up)        cnt_q <= cnt_q + 1'b1;
      else                      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_wr && !restart) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/wdt_lfsr_timer.sv
module wdt_lfsr_timer
  import wdt_pkg::*;
#(
  parameter int           CNT_W     = 16,
  parameter int           DATA_W    = 16,
  parameter int           LFSR_W    = 8,
  parameter logic [7:0]   LFSR_TAPS = 8'h63,
  parameter int           PSC_MID   = 4,
  parameter int           PSC_HI    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              load_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq,
  output logic              rst_req
);

  localparam int CTL_W = $bits(ctl_t);

  ctl_t              ctl_q;
  logic              tick;
  logic              expire;
  logic [LFSR_W-1:0] expect_val;
  logic              clr_live;
  logic              seed_ld;
  logic              sec_chk;
  logic              seq_ok;
  logic              seq_bad;
  logic              restart;

  always_ff @(posedge clk) begin
    if (rst)                   ctl_q <= '0;
    else if (ctrl_we && !ctl_q.wd) ctl_q <= ctl_t'(wdata[CTL_LSB +: CTL_W]);
  end

  always_comb begin
    clr_live = clr_we & ctl_q.en;
    seed_ld  = clr_we & ~ctl_q.wd;
    sec_chk  = clr_live & ctl_q.wd & ctl_q.secure;
    seq_ok   = (wdata[LFSR_W-1:0] == expect_val) && (expect_val != '0);
    seq_bad  = sec_chk & ~seq_ok;
    restart  = clr_live & ctl_q.wd & (~ctl_q.secure | seq_ok);
  end

  wdt_prescaler #(.LOG_MID(PSC_MID), .LOG_HI(PSC_HI)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (ctl_q.en),
    .sel  (ctl_q.psc),
    .tick (tick)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .count_up (ctl_q.up),
    .periodic (ctl_q.periodic),
    .load_wr  (load_we),
    .load_val (wdata[CNT_W-1:0]),
    .restart  (restart),
    .expire   (expire)
  );

  wdt_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0])) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (seed_ld),
    .seed  (wdata[LFSR_W-1:0]),
    .step  (sec_chk & seq_ok),
    .state (expect_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= (expire & ctl_q.wd & ~ctl_q.wd_irq) | seq_bad;
      if (expire && (!ctl_q.wd || ctl_q.wd_irq)) irq <= 1'b1;
      else if (clr_live)                          irq <= 1'b0;
    end
  end

  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    ctl_q.wd |=> $stable(ctl_q)); // R13

  AST_RSTREQ_WD_ONLY: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(ctl_q.wd)); // R8

  AST_IRQ_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(clr_we && ctl_q.en) || $past(rst))); // R7

endmodule

// File: tb/wdt_lfsr_timer_tb.sv
module wdt_lfsr_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic        load_we = 1'b0;
  logic        clr_we = 1'b0;
  logic [15:0] wdata = '0;
  logic        irq;
  logic        rst_req;

  always #5 clk = ~clk;

  wdt_lfsr_timer u_dut (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (ctrl_we),
    .load_we (load_we),
    .clr_we  (clr_we),
    .wdata   (wdata),
    .irq     (irq),
    .rst_req (rst_req)
  );

  typedef struct {
    int    stamp;
    int    e_irq;   // -1 = don't care
    int    e_rst;
    string req;
  } item_t;

  item_t sb[$];
  item_t it;
  int    cyc = 0;
  int    w_edge = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares queued expectations with the outputs at their edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].stamp <= cyc) begin
      it = sb.pop_front();
      n_vec++;
      if (it.stamp != cyc) begin
        n_bad++;
        $display("FAIL %s late check: actual cycle %0d expected cycle %0d", it.req, cyc, it.stamp);
      end else if ((it.e_irq >= 0 && irq !== it.e_irq[0]) ||
                   (it.e_rst >= 0 && rst_req !== it.e_rst[0])) begin
        n_bad++;
        $display("FAIL %s @edge %0d: actual irq=%b rst_req=%b expected irq=%0d rst_req=%0d",
                 it.req, cyc, irq, rst_req, it.e_irq, it.e_rst);
      end
    end
  end

  // Driver side: expectation k edges after the last write edge.
  task automatic expect_out(input int k, input int ei, input int er, input string req);
    item_t x;
    x.stamp = w_edge + k; x.e_irq = ei; x.e_rst = er; x.req = req;
    sb.push_back(x);
  endtask

  task automatic bus_wr(input int kind, input logic [15:0] d);
    @(posedge clk); #1;
    ctrl_we = (kind == 0); load_we = (kind == 1); clr_we = (kind == 2);
    wdata = d;
    w_edge = cyc + 1;
    @(posedge clk); #1;
    ctrl_we = 0; load_we = 0; clr_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    while (sb.size() > 0) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    drain();
    @(posedge clk); #1; rst = 1;
    w_edge = cyc + 1;
    @(posedge clk); #1; rst = 0;
    expect_out(0, 0, 0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();

    // R3 down periodic /1, R6 sticky irq and clear
    bus_wr(1, 16'd3);
    bus_wr(0, 16'h00C0);
    expect_out(3, 0, 0, "R3"); expect_out(4, 1, 0, "R3"); expect_out(6, 1, 0, "R6");
    idle(5);
    bus_wr(2, 16'h0000);
    expect_out(0, 0, -1, "R6"); expect_out(1, 1, -1, "R3");

    // R2 prescale /16
    do_reset();
    bus_wr(1, 16'd1);
    bus_wr(0, 16'h00C4);
    expect_out(31, 0, -1, "R2"); expect_out(32, 1, -1, "R2");

    // R2 prescale /256
    do_reset();
    bus_wr(1, 16'd0);
    bus_wr(0, 16'h00C8);
    expect_out(255, 0, -1, "R2"); expect_out(256, 1, -1, "R2");

    // R2 prescale code 11 acts as /1
    do_reset();
    bus_wr(1, 16'd2);
    bus_wr(0, 16'h00CC);
    expect_out(2, 0, -1, "R2"); expect_out(3, 1, -1, "R2");

    // R4 count up, periodic reload
    do_reset();
    bus_wr(1, 16'hFFFD);
    bus_wr(0, 16'h01C0);
    expect_out(2, 0, -1, "R4"); expect_out(3, 1, -1, "R4");
    idle(2);
    bus_wr(2, 16'h0000);
    expect_out(0, 0, -1, "R4"); expect_out(1, 0, -1, "R4"); expect_out(2, 1, -1, "R4");

    // R5 count up, free-running wraps to 0
    do_reset();
    bus_wr(1, 16'hFFFD);
    bus_wr(0, 16'h0180);
    expect_out(3, 1, -1, "R5");
    idle(2);
    bus_wr(2, 16'h0000);
    expect_out(0, 0, -1, "R5"); expect_out(2, 0, -1, "R5"); expect_out(6, 0, -1, "R5");

    // R7 restart write ignored while disabled
    do_reset();
    bus_wr(1, 16'd0);
    bus_wr(0, 16'h00C0);
    expect_out(1, 1, -1, "R7");
    bus_wr(0, 16'h0040);
    bus_wr(2, 16'h0000);
    expect_out(0, 1, -1, "R7"); expect_out(2, 1, -1, "R7");

    // R8 watchdog expiry pulse, R13 lock
    do_reset();
    bus_wr(1, 16'd5);
    bus_wr(0, 16'h00E0);
    expect_out(5, 0, 0, "R8"); expect_out(6, 0, 1, "R8"); expect_out(7, 0, 0, "R8");
    bus_wr(0, 16'h0000);
    expect_out(9, -1, 0, "R13"); expect_out(10, 0, 1, "R13");

    // R10 non-secure restart
    do_reset();
    bus_wr(1, 16'd5);
    bus_wr(0, 16'h00E0);
    idle(1);
    bus_wr(2, 16'h0055);
    expect_out(3, -1, 0, "R10"); expect_out(5, -1, 0, "R10"); expect_out(6, -1, 1, "R10");

    // R9 interrupt instead of reset
    do_reset();
    bus_wr(1, 16'd2);
    bus_wr(0, 16'h00E2);
    expect_out(2, 0, 0, "R9"); expect_out(3, 1, 0, "R9"); expect_out(5, 1, 0, "R9");

    // R11 secure sequence from seed 0xAA
    do_reset();
    bus_wr(2, 16'h00AA);
    bus_wr(1, 16'd100);
    bus_wr(0, 16'h00F0);
    bus_wr(2, 16'h00AA); expect_out(0, -1, 0, "R11");
    bus_wr(2, 16'h0037); expect_out(0, -1, 0, "R11");
    bus_wr(2, 16'h006E); expect_out(0, -1, 0, "R11");
    bus_wr(2, 16'h0066); expect_out(0, -1, 1, "R11"); expect_out(1, -1, 0, "R11");
    bus_wr(2, 16'h00DC); expect_out(0, -1, 0, "R11");

    // R12 zero seed traps every write
    do_reset();
    bus_wr(2, 16'h0000);
    bus_wr(1, 16'd100);
    bus_wr(0, 16'h00F0);
    bus_wr(2, 16'h0000); expect_out(0, -1, 1, "R12");

    drain();
    idle(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule